// File: doc/BRIEF.md
# Triggered Synchronous Serial Port

This block moves one byte at a time over a three-wire clocked serial link (clock, data out, data in). It can drive the serial clock itself as a master, or follow an external clock as a slave. A host reaches it through a narrow register interface with 4-bit data. The byte register spans two nibble addresses. One control register holds enable, bit order and master/slave mode. A command/status address starts a transfer and reports progress.

A transfer is gated on purpose. The host must first touch the byte register, by a read or a write, while the port is idle. That access arms the port. A start command is honoured only when the port is both armed and enabled. Once running, the port ignores further start commands and all byte-register accesses until eight serial clocks have passed. Outgoing bits change on the falling clock edge and incoming bits are taken on the rising edge. After the eighth rising edge the port falls idle and raises a completion flag. The bit order used for a transfer is the one in force when the byte register was last written. In master mode the serial clock is made by dividing a host-supplied clock-enable strobe. The host must keep the resulting rate at or below 1 MHz when a fast source drives that strobe, and must keep an external clock in slave mode at or below 1 MHz.

Top module: `trig_sio`

## Requirements
- R1: After reset the status, control and byte registers read 0, and `sclk_out`, `sdo` are 1 while `done_o` is 0.
- R2: A read or write of a byte nibble (address 0 = bits 3:0, address 1 = bits 7:4) while idle sets the armed bit (status bit 2, status at address 3).
- R3: Writing address 3 with data bit 0 set starts a transfer only if the port is armed, enabled (control bit 0, control at address 2) and idle. A start sets busy (status bit 0) and clears armed and done. Otherwise the command changes nothing.
- R4: While busy, start commands are ignored. Byte-register writes alter no data, and byte-register reads do not arm.
- R5: In master mode (control bit 2 = 0), `sclk_out` idles high, advances one half period every HALF_TICKS cycles with `tick_en` high, and gives exactly eight low pulses per transfer.
- R6: `sdo` changes only on a falling serial clock edge, and `sdi` is captured on the rising edge.
- R7: Control bit 1 = 1 selects MSB-first, 0 selects LSB-first. The order used is the value held at the last byte-register write.
- R8: In slave mode (control bit 2 = 1), edges on `sclk_in` have no effect while idle, and `sclk_out` stays high.
- R9: After the eighth rising edge busy clears, done (status bit 1 and `done_o`) sets, and the byte register holds the received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (arms on byte reads) |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register read data (combinational on address) |
| tick_en | input | 1 | Clock-enable strobe divided into the master clock |
| sclk_in | input | 1 | External serial clock (slave mode) |
| sdi | input | 1 | Serial data in |
| sclk_out | output | 1 | Serial clock driven in master mode |
| sdo | output | 1 | Serial data out |
| done_o | output | 1 | Completion flag |

## Verification
The bench attacks the gating sequence. It tries a start with no prior byte access, a start with the port disabled, and repeated starts plus byte writes and reads in the middle of a transfer. A port that skipped arming or restarted on a second command would begin a transfer, stretch one, or corrupt the received byte. It latches MSB-first, switches the control bit to LSB-first before starting, and expects the old order on the wire; a port that read the live bit would send the byte reversed. It toggles the slave clock while idle, where a port that counted those edges would shift its data, and it also runs random bytes, orders and modes with an irregular `tick_en` strobe against bit-order functions.

// File: rtl/trig_sio_pkg.sv
package trig_sio_pkg;

   typedef struct packed {
      logic slave;
      logic msb_first;
      logic enable;
   } sio_ctrl_t;

   localparam int unsigned NIB_W = 4;

endpackage

// File: rtl/trig_sio_clkgen.sv
module trig_sio_clkgen #(
   parameter int unsigned HALF_TICKS  = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic slave,
   input  logic tick_en,
   input  logic sclk_in,
   output logic fall_ev,
   output logic rise_ev,
   output logic sclk_out
);

   localparam int unsigned CNT_W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;

   if (HALF_TICKS < 1) begin : g_bad_half
      $error("HALF_TICKS must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic sclk_q;
   logic half_done;
   logic m_fall, m_rise;
   logic s_fall, s_rise;

   // master divider: counter variant or direct toggle variant
   if (HALF_TICKS == 1) begin : g_direct
      assign half_done = tick_en;
   end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (!run || slave) begin
            cnt_q <= '0;
         end else if (tick_en) begin
            if (cnt_q == CNT_W'(HALF_TICKS - 1)) cnt_q <= '0;
            else                                 cnt_q <= cnt_q + 1'b1;
         end
      end
      assign half_done = tick_en && (cnt_q == CNT_W'(HALF_TICKS - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b1;
      end else if (!run || slave) begin
         sclk_q <= 1'b1;
      end else if (half_done) begin
         sclk_q <= ~sclk_q;
      end
   end

   assign m_fall = run && !slave && half_done && sclk_q;
   assign m_rise = run && !slave && half_done && !sclk_q;

   // external clock synchroniser chain plus one delay stage for edge detect
   logic [SYNC_STAGES:0] sync_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[0] <= 1'b1;
      else        sync_q[0] <= sclk_in;
   end
   for (genvar s = 1; s <= SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[s] <= 1'b1;
         else        sync_q[s] <= sync_q[s-1];
      end
   end

   assign s_rise = run && slave && sync_q[SYNC_STAGES-1] && !sync_q[SYNC_STAGES];
   assign s_fall = run && slave && !sync_q[SYNC_STAGES-1] && sync_q[SYNC_STAGES];

   assign fall_ev  = m_fall || s_fall;
   assign rise_ev  = m_rise || s_rise;
   assign sclk_out = sclk_q;

   a_r6_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
      !(fall_ev && rise_ev));

   a_r8_slave_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
      slave |=> sclk_out);

endmodule

// File: rtl/trig_sio_shifter.sv
module trig_sio_shifter #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              fall_ev,
   input  logic              rise_ev,
   input  logic              sdi,
   input  logic [DATA_W/4-1:0] wr_nib_en,
   input  logic [3:0]        wr_nib,
   input  logic              order_in,
   output logic [DATA_W-1:0] data,
   output logic              sdo,
   output logic              busy,
   output logic              done_pulse
);

   localparam int unsigned NIB   = DATA_W / 4;
   localparam int unsigned CNT_W = $clog2(DATA_W + 1);

   if (DATA_W < 4 || (DATA_W % 4) != 0) begin : g_bad_width
      $error("DATA_W must be a positive multiple of 4");
   end

   logic [DATA_W-1:0] shreg_q;
   logic [CNT_W-1:0]  bits_q;
   logic              busy_q;
   logic              order_q;
   logic              sdo_q;
   logic              last_bit;

   assign last_bit = (bits_q == CNT_W'(DATA_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         order_q <= 1'b0;
      end else if (!busy_q) begin
         for (int n = 0; n < NIB; n++) begin
            if (wr_nib_en[n]) shreg_q[4*n +: 4] <= wr_nib;
         end
         if (|wr_nib_en) order_q <= order_in;
      end else if (rise_ev) begin
         if (order_q) shreg_q <= {shreg_q[DATA_W-2:0], sdi};
         else         shreg_q <= {sdi, shreg_q[DATA_W-1:1]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         bits_q <= '0;
      end else if (start && !busy_q) begin
         busy_q <= 1'b1;
         bits_q <= '0;
      end else if (busy_q && rise_ev) begin
         bits_q <= bits_q + 1'b1;
         if (last_bit) busy_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                sdo_q <= 1'b1;
      else if (busy_q && fall_ev) sdo_q <= order_q ? shreg_q[DATA_W-1] : shreg_q[0];
   end

   assign data       = shreg_q;
   assign sdo        = sdo_q;
   assign busy       = busy_q;
   assign done_pulse = busy_q && rise_ev && last_bit;

   a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      bits_q <= CNT_W'(DATA_W));

   a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !(|wr_nib_en)) |=> $stable(shreg_q));

   a_r6_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_ev |=> $stable(sdo_q));

endmodule

// File: rtl/trig_sio.sv
module trig_sio
   import trig_sio_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned HALF_TICKS  = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_re,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [3:0]        reg_wdata,
   output logic [3:0]        reg_rdata,
   input  logic              tick_en,
   input  logic              sclk_in,
   input  logic              sdi,
   output logic              sclk_out,
   output logic              sdo,
   output logic              done_o
);

   localparam int unsigned NIB    = DATA_W / NIB_W;
   localparam int unsigned CTRL_A = NIB;
   localparam int unsigned CMD_A  = NIB + 1;

   if (CMD_A >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   sio_ctrl_t         ctrl_q;
   logic              armed_q;
   logic              done_q;
   logic              busy;
   logic              done_pulse;
   logic              fall_ev, rise_ev;
   logic [DATA_W-1:0] data;
   logic [NIB-1:0]    wr_nib_en;
   logic              data_sel;
   logic              start_cmd;
   logic              accept;
   logic [3:0]        nib_rd;

   assign data_sel  = 32'(reg_addr) < NIB;
   assign start_cmd = reg_we && (32'(reg_addr) == CMD_A) && reg_wdata[0];
   assign accept    = start_cmd && armed_q && ctrl_q.enable && !busy;

   always_comb begin
      for (int n = 0; n < NIB; n++) begin
         wr_nib_en[n] = reg_we && !busy && (32'(reg_addr) == n);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         armed_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         if (reg_we && (32'(reg_addr) == CTRL_A)) ctrl_q <= sio_ctrl_t'(reg_wdata[2:0]);
         if (accept)                                        armed_q <= 1'b0;
         else if ((reg_we || reg_re) && data_sel && !busy)  armed_q <= 1'b1;
         if (accept)          done_q <= 1'b0;
         else if (done_pulse) done_q <= 1'b1;
      end
   end

   always_comb begin
      nib_rd = '0;
      for (int n = 0; n < NIB; n++) begin
         if (32'(reg_addr) == n) nib_rd = data[4*n +: 4];
      end
   end

   always_comb begin
      if (data_sel)                        reg_rdata = nib_rd;
      else if (32'(reg_addr) == CTRL_A)    reg_rdata = {1'b0, ctrl_q};
      else if (32'(reg_addr) == CMD_A)     reg_rdata = {1'b0, armed_q, done_q, busy};
      else                                 reg_rdata = '0;
   end

   trig_sio_clkgen #(
      .HALF_TICKS (HALF_TICKS),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_clkgen (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .slave   (ctrl_q.slave),
      .tick_en (tick_en),
      .sclk_in (sclk_in),
      .fall_ev (fall_ev),
      .rise_ev (rise_ev),
      .sclk_out(sclk_out)
   );

   trig_sio_shifter #(
      .DATA_W(DATA_W)
   ) u_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .fall_ev   (fall_ev),
      .rise_ev   (rise_ev),
      .sdi       (sdi),
      .wr_nib_en (wr_nib_en),
      .wr_nib    (reg_wdata),
      .order_in  (ctrl_q.msb_first),
      .data      (data),
      .sdo       (sdo),
      .busy      (busy),
      .done_pulse(done_pulse)
   );

   assign done_o = done_q;

   a_r3_start_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(armed_q && ctrl_q.enable));

   a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sclk_out);

   a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done_q);

endmodule

// File: tb/trig_sio_bench.sv
module trig_sio_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_we = 1'b0;
   logic       reg_re = 1'b0;
   logic [1:0] reg_addr = '0;
   logic [3:0] reg_wdata = '0;
   logic [3:0] reg_rdata;
   logic       tick_en = 1'b0;
   logic       sclk_in = 1'b1;
   logic       sdi = 1'b0;
   logic       sclk_out, sdo, done_o;

   int n_total = 0;
   int n_fail  = 0;
   int fall_cnt = 0;
   bit tick_hold = 1'b0;
   bit tick_rand = 1'b0;

   always #5 clk = ~clk;

   trig_sio #(.DATA_W(8), .HALF_TICKS(3), .SYNC_STAGES(2), .ADDR_W(2)) u_trig_sio (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_en(tick_en), .sclk_in(sclk_in),
      .sdi(sdi), .sclk_out(sclk_out), .sdo(sdo), .done_o(done_o));

   always @(negedge clk) begin
      if (tick_hold)      tick_en = 1'b0;
      else if (tick_rand) tick_en = 1'($urandom % 2);
      else                tick_en = 1'b1;
   end

   always @(negedge sclk_out) fall_cnt++;

   function automatic logic wire_bit(input logic [7:0] d, input logic msb, input int i);
      return msb ? d[7-i] : d[i];
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_total++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   endtask

   task automatic wr(input logic [1:0] a, input logic [3:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [3:0] v);
      @(negedge clk);
      reg_addr = a; reg_re = 1'b1;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_re = 1'b0;
   endtask

   task automatic load(input logic [7:0] d);
      wr(2'd0, d[3:0]);
      wr(2'd1, d[7:4]);
   endtask

   task automatic read_byte(output logic [7:0] d);
      logic [3:0] lo, hi;
      rd(2'd0, lo);
      rd(2'd1, hi);
      d = {hi, lo};
   endtask

   // starts a transfer (already armed/enabled) and plays the far end
   task automatic xfer(input logic slave, input logic ord, input logic [7:0] tx,
                       input logic [7:0] rx, input bit pokes, input string tag);
      logic [3:0] st;
      logic [7:0] got;
      logic [7:0] back;
      int f0;
      got = '0;
      if (pokes) tick_hold = 1'b1;
      f0 = fall_cnt;
      wr(2'd3, 4'h1);
      rd(2'd3, st);
      chk({"R3 start accepted ", tag}, int'(st), 32'h1);
      if (pokes) begin
         wr(2'd3, 4'h1);        // second start while running (R4)
         wr(2'd0, 4'hF);        // data write while running (R4)
         wr(2'd1, 4'hF);
         rd(2'd0, st);          // data read while running, must not arm (R4)
         rd(2'd3, st);
         chk("R4 running access leaves armed clear", int'(st), 32'h1);
         tick_hold = 1'b0;
      end
      for (int i = 0; i < 8; i++) begin
         if (!slave) begin
            @(negedge sclk_out);
            #1 sdi = wire_bit(rx, ord, i);
            @(posedge sclk_out);
            #1 got[i] = sdo;
         end else begin
            sclk_in = 1'b0;
            repeat (8) @(negedge clk);
            got[i] = sdo;
            sdi = wire_bit(rx, ord, i);
            sclk_in = 1'b1;
            repeat (8) @(negedge clk);
         end
      end
      repeat (6) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         chk({"R6 R7 out bit ", tag}, int'(got[i]), int'(wire_bit(tx, ord, i)));
      end
      if (!slave) chk({"R5 eight clock pulses ", tag}, fall_cnt - f0, 8);
      else        chk({"R8 no master clock in slave ", tag}, fall_cnt - f0, 0);
      chk({"R5 clock idles high ", tag}, int'(sclk_out), 1);
      rd(2'd3, st);
      chk({"R9 status after end ", tag}, int'(st), 32'h2);
      chk({"R9 done_o ", tag}, int'(done_o), 1);
      if (pokes) begin
         wr(2'd3, 4'h1);
         rd(2'd3, st);
         chk("R4 extra start after run not honoured", int'(st), 32'h2);
      end
      read_byte(back);
      chk({"R9 received byte ", tag}, int'(back), int'(rx));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_total++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [3:0] st;
      logic [7:0] b;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(2'd3, st);  chk("R1 status", int'(st), 0);
      rd(2'd2, st);  chk("R1 control", int'(st), 0);
      chk("R1 sclk_out", int'(sclk_out), 1);
      chk("R1 sdo", int'(sdo), 1);
      chk("R1 done_o", int'(done_o), 0);
      read_byte(b);  chk("R1 data", int'(b), 0);

      // R3 start without arming: enable only
      wr(2'd0, 4'h0);                 // arms via write (R2), then reset arming by... keep unarmed check first
      // fresh check: clear arming by a disabled state is not possible; use reset instead
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
      wr(2'd2, 4'h1);
      wr(2'd3, 4'h1);
      rd(2'd3, st);  chk("R3 start ignored when not armed", int'(st), 0);

      // R2 arm by read, R3 start ignored when disabled
      wr(2'd2, 4'h0);
      rd(2'd1, st);
      rd(2'd3, st);  chk("R2 read arms", int'(st), 32'h4);
      wr(2'd3, 4'h1);
      rd(2'd3, st);  chk("R3 start ignored when disabled", int'(st), 32'h4);

      // R8 slave edges while idle do nothing
      wr(2'd2, 4'h4);
      load(8'h96);
      for (int k = 0; k < 10; k++) begin
         sclk_in = ~sclk_in;
         repeat (5) @(negedge clk);
      end
      sclk_in = 1'b1;
      repeat (5) @(negedge clk);
      read_byte(b);  chk("R8 idle slave clock leaves data", int'(b), 32'h96);
      rd(2'd3, st);  chk("R8 idle slave clock no busy", int'(st), 32'h4);
      chk("R8 sclk_out high in slave", int'(sclk_out), 1);

      // directed master MSB-first with accesses during the run (R4)
      wr(2'd2, 4'h3);
      load(8'hA5);
      rd(2'd3, st);  chk("R2 write arms", int'(st), 32'h4);
      xfer(1'b0, 1'b1, 8'hA5, 8'h3C, 1'b1, "master msb");

      // R7 order latched at load: load MSB-first, then switch control to LSB-first
      wr(2'd2, 4'h3);
      load(8'h1E);
      wr(2'd2, 4'h1);
      xfer(1'b0, 1'b1, 8'h1E, 8'hC3, 1'b0, "latched order");
      rd(2'd3, st);
      // R3 done cleared by the next start
      load(8'h00);
      wr(2'd3, 4'h1);
      rd(2'd3, st);  chk("R3 start clears done", int'(st), 32'h1);
      repeat (80) @(negedge clk);

      // directed slave LSB-first
      wr(2'd2, 4'h5);
      load(8'h6B);
      xfer(1'b1, 1'b0, 8'h6B, 8'hD2, 1'b0, "slave lsb");

      // random transfers
      tick_rand = 1'b1;
      for (int t = 0; t < 10; t++) begin
         logic sl, ord;
         logic [7:0] tx, rx;
         sl  = 1'($urandom % 2);
         ord = 1'($urandom % 2);
         tx  = 8'($urandom);
         rx  = 8'($urandom);
         wr(2'd2, {1'b0, sl, ord, 1'b1});
         load(tx);
         xfer(sl, ord, tx, rx, 1'b0, "random");
      end
      tick_rand = 1'b0;

      finish_run();
   end

endmodule